// File: doc/BRIEF.md
# Processor Control Register File

This block is the control-register bank of a 32-bit processor core. It keeps the current status byte, a backup status byte, a second-level backup status byte, a separately stored condition bit, banked interrupt and user stack pointers, a backup and a second-level backup program counter, and two scratch words. Software reaches all of them through one combinational read port and one clocked write port, each addressed by a control-register index.

The general-purpose stack-pointer register lives outside the block. A side port reads its value and can overwrite it. Bit 7 of the current status byte selects the stack mode. Any status write that flips this bit exchanges the live stack pointer with the banked pointer for the new mode. Accesses to the interrupt or user stack-pointer index are routed to the live register when that pointer is the active one, and to the banked slot when it is not.

Top module: `ctl_reg_bank`

## Requirements
- R1: After synchronous reset every stored field is zero. Index 2 then reads the live stack pointer and every other index reads zero. `sp_live_we` is low whenever no write is requested.
- R2: Index 0 (status word) reads as bits 15:8 = backup byte AND 0xC1, bits 7:1 = current byte AND 0xC0, bit 0 = condition bit, and bits 31:16 = 0.
- R3: A write to index 0 loads data bits 15:8 into the backup byte and bits 7:0 into the current byte, and sets the condition bit from bit 0. The stack-mode bit is bit 7 of the current byte.
- R4: If a status write takes the stack-mode bit from 1 to 0, the live stack pointer is saved into the user slot and the interrupt slot is written to the live stack pointer, on the same clock edge.
- R5: If a status write takes the stack-mode bit from 0 to 1, the live stack pointer is saved into the interrupt slot and the user slot is written to the live stack pointer. A status write that leaves the mode bit unchanged does not touch the stack pointers.
- R6: Index 2 (interrupt stack pointer) reads and writes the live stack pointer when the mode bit is 0, and the banked slot otherwise. Index 3 (user stack pointer) reads and writes the live stack pointer when the mode bit is 1, and the banked slot otherwise.
- R7: Index 6 (backup PC) and index 8 (second-level backup PC) store all 32 written bits and read with bit 0 forced to 0.
- R8: Index 7 (second-level backup status) is written from data bits 7:0 and reads as that byte AND 0xC1.
- R9: Index 1 (condition bit) reads as the condition bit in bit 0 with all other bits zero. A write to it sets the condition bit from data bit 0.
- R10: Indices 4 and 5 are independent 32-bit scratch words. Every other index (9 to 15) reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request for `wr_idx` |
| wr_idx | input | 4 | Index of the register to write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 4 | Index of the register to read |
| rd_data | output | 32 | Combinational read data |
| sp_live_in | input | 32 | Current value of the live stack-pointer register |
| sp_live_we | output | 1 | Load strobe for the live stack-pointer register |
| sp_live_out | output | 32 | Value to load into the live stack-pointer register |

## Verification
A wrong stack-mode bit shows on the very next read of index 2 or 3, which then returns the banked slot where it should return the live pointer, or the other way round. A missed or reversed swap leaves the external stack-pointer register holding a wrong value straight after the status write. The lost banked value stays hidden until the mode is flipped back, so the bench reads every index after every write and compares the external register on each edge. Masking errors show only in the bits that the read port should clear, so stored bytes are written with all ones.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int unsigned CR_STAT = 0;
  localparam int unsigned CR_COND = 1;
  localparam int unsigned CR_ISP  = 2;
  localparam int unsigned CR_USP  = 3;
  localparam int unsigned CR_SCR0 = 4;
  localparam int unsigned CR_BPC  = 6;
  localparam int unsigned CR_BBST = 7;
  localparam int unsigned CR_BBPC = 8;

  localparam logic [7:0] BACK_MASK = 8'hC1;
  localparam logic [7:0] CUR_MASK  = 8'hC0;
  localparam int unsigned MODE_BIT = 7;

  typedef enum logic [1:0] {
    SW_NONE   = 2'd0,
    SW_TO_INT = 2'd1,
    SW_TO_USR = 2'd2
  } swap_e;

  function automatic logic [15:0] pack_status(input logic [7:0] bst,
                                              input logic [7:0] cur,
                                              input logic       cond);
    return {bst & BACK_MASK, (cur & CUR_MASK) | {7'b0, cond}};
  endfunction

  function automatic logic [7:0] view_backup(input logic [7:0] b);
    return b & BACK_MASK;
  endfunction

endpackage

// File: rtl/ctl_status_unit.sv
module ctl_status_unit
  import ctlreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        stat_we,
  input  logic        cond_we,
  input  logic [15:0] wdata,
  output logic        mode,
  output logic        cond,
  output logic [15:0] stat_word,
  output swap_e       swap
);

  logic [7:0] bst_q;
  logic [7:0] cur_q;
  logic       cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bst_q  <= '0;
      cur_q  <= '0;
      cond_q <= 1'b0;
    end else if (stat_we) begin
      bst_q  <= wdata[15:8] & BACK_MASK;
      cur_q  <= wdata[7:0] & CUR_MASK;
      cond_q <= wdata[0];
    end else if (cond_we) begin
      cond_q <= wdata[0];
    end
  end

  assign mode      = cur_q[MODE_BIT];
  assign cond      = cond_q;
  assign stat_word = pack_status(bst_q, cur_q, cond_q);

  always_comb begin
    swap = SW_NONE;
    if (stat_we && (wdata[MODE_BIT] != mode))
      swap = mode ? SW_TO_INT : SW_TO_USR;
  end

  assert_mode_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    stat_we |=> mode == $past(wdata[MODE_BIT]));

  assert_cond_write_R9: assert property (@(posedge clk) disable iff (rst)
    (cond_we && !stat_we) |=> cond == $past(wdata[0]));

endmodule

// File: rtl/ctl_sp_bank.sv
module ctl_sp_bank
  import ctlreg_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  swap_e         swap,
  input  logic          mode,
  input  logic          isp_acc_we,
  input  logic          usp_acc_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] live_in,
  output logic [DW-1:0] isp_view,
  output logic [DW-1:0] usp_view,
  output logic          live_we,
  output logic [DW-1:0] live_out
);

  logic [DW-1:0] isp_q;
  logic [DW-1:0] usp_q;
  logic          isp_is_live;
  logic          usp_is_live;

  assign isp_is_live = !mode;
  assign usp_is_live = mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      isp_q <= '0;
      usp_q <= '0;
    end else begin
      unique case (swap)
        SW_TO_INT: usp_q <= live_in;
        SW_TO_USR: isp_q <= live_in;
        default: begin
          if (isp_acc_we && !isp_is_live) isp_q <= wdata;
          if (usp_acc_we && !usp_is_live) usp_q <= wdata;
        end
      endcase
    end
  end

  assign isp_view = isp_is_live ? live_in : isp_q;
  assign usp_view = usp_is_live ? live_in : usp_q;

  always_comb begin
    live_we  = 1'b0;
    live_out = '0;
    unique case (swap)
      SW_TO_INT: begin live_we = 1'b1; live_out = isp_q; end
      SW_TO_USR: begin live_we = 1'b1; live_out = usp_q; end
      default: begin
        if ((isp_acc_we && isp_is_live) || (usp_acc_we && usp_is_live)) begin
          live_we  = 1'b1;
          live_out = wdata;
        end
      end
    endcase
  end

  assert_swap_to_int_saves_R4: assert property (@(posedge clk) disable iff (rst)
    (swap == SW_TO_INT) |=> usp_q == $past(live_in));

  assert_swap_to_usr_saves_R5: assert property (@(posedge clk) disable iff (rst)
    (swap == SW_TO_USR) |=> isp_q == $past(live_in));

  assert_live_access_keeps_bank_R6: assert property (@(posedge clk) disable iff (rst)
    (swap == SW_NONE && isp_acc_we && isp_is_live) |=> $stable(isp_q));

endmodule

// File: rtl/ctl_aux_store.sv
module ctl_aux_store
  import ctlreg_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned IW      = 4,
  parameter int unsigned NUM_SCR = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [IW-1:0]              idx,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              bpc_q,
  output logic [DW-1:0]              bbpc_q,
  output logic [7:0]                 bbst_q,
  output logic [NUM_SCR-1:0][DW-1:0] scr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bpc_q  <= '0;
      bbpc_q <= '0;
      bbst_q <= '0;
    end else if (we) begin
      if (idx == IW'(CR_BPC))  bpc_q  <= wdata;
      if (idx == IW'(CR_BBPC)) bbpc_q <= wdata;
      if (idx == IW'(CR_BBST)) bbst_q <= view_backup(wdata[7:0]);
    end
  end

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst)
        scr_q[g] <= '0;
      else if (we && idx == IW'(CR_SCR0 + g))
        scr_q[g] <= wdata;
    end
  end

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctlreg_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned IW      = 4,
  parameter int unsigned NUM_SCR = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] sp_live_in,
  output logic          sp_live_we,
  output logic [DW-1:0] sp_live_out
);

  logic                       mode;
  logic                       cond;
  logic [15:0]                stat_word;
  swap_e                      swap;
  logic [DW-1:0]              isp_view;
  logic [DW-1:0]              usp_view;
  logic [DW-1:0]              bpc_q;
  logic [DW-1:0]              bbpc_q;
  logic [7:0]                 bbst_q;
  logic [NUM_SCR-1:0][DW-1:0] scr_q;

  logic stat_we, cond_we, isp_we, usp_we;
  assign stat_we = wr_en && wr_idx == IW'(CR_STAT);
  assign cond_we = wr_en && wr_idx == IW'(CR_COND);
  assign isp_we  = wr_en && wr_idx == IW'(CR_ISP);
  assign usp_we  = wr_en && wr_idx == IW'(CR_USP);

  ctl_status_unit u_status (
    .clk       (clk),
    .rst       (rst),
    .stat_we   (stat_we),
    .cond_we   (cond_we),
    .wdata     (wr_data[15:0]),
    .mode      (mode),
    .cond      (cond),
    .stat_word (stat_word),
    .swap      (swap)
  );

  ctl_sp_bank #(.DW(DW)) u_sp (
    .clk        (clk),
    .rst        (rst),
    .swap       (swap),
    .mode       (mode),
    .isp_acc_we (isp_we),
    .usp_acc_we (usp_we),
    .wdata      (wr_data),
    .live_in    (sp_live_in),
    .isp_view   (isp_view),
    .usp_view   (usp_view),
    .live_we    (sp_live_we),
    .live_out   (sp_live_out)
  );

  ctl_aux_store #(.DW(DW), .IW(IW), .NUM_SCR(NUM_SCR)) u_aux (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en),
    .idx    (wr_idx),
    .wdata  (wr_data),
    .bpc_q  (bpc_q),
    .bbpc_q (bbpc_q),
    .bbst_q (bbst_q),
    .scr_q  (scr_q)
  );

  function automatic logic [DW-1:0] even_pc(input logic [DW-1:0] pc);
    return {pc[DW-1:1], 1'b0};
  endfunction

  logic rd_unassigned;

  always_comb begin
    rd_data       = '0;
    rd_unassigned = 1'b0;
    if (rd_idx == IW'(CR_STAT))      rd_data = DW'(stat_word);
    else if (rd_idx == IW'(CR_COND)) rd_data = DW'(cond);
    else if (rd_idx == IW'(CR_ISP))  rd_data = isp_view;
    else if (rd_idx == IW'(CR_USP))  rd_data = usp_view;
    else if (rd_idx == IW'(CR_BPC))  rd_data = even_pc(bpc_q);
    else if (rd_idx == IW'(CR_BBPC)) rd_data = even_pc(bbpc_q);
    else if (rd_idx == IW'(CR_BBST)) rd_data = DW'(view_backup(bbst_q));
    else if (int'(rd_idx) >= CR_SCR0 && int'(rd_idx) < CR_SCR0 + NUM_SCR)
      rd_data = scr_q[int'(rd_idx) - CR_SCR0];
    else
      rd_unassigned = 1'b1;
  end

  assert_pc_even_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == IW'(CR_BPC) || rd_idx == IW'(CR_BBPC)) |-> !rd_data[0]);

  assert_unassigned_zero_R10: assert property (@(posedge clk) disable iff (rst)
    rd_unassigned |-> rd_data == '0);

  assert_bbst_mask_R8: assert property (@(posedge clk) disable iff (rst)
    rd_idx == IW'(CR_BBST) |-> (rd_data & ~DW'(BACK_MASK)) == '0);

  assert_quiet_sp_port_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !sp_live_we);

  assert_stat_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rd_idx == IW'(CR_STAT) |-> rd_data[DW-1:16] == '0);

endmodule

// File: tb/ctl_reg_bank_bench.sv
`timescale 1ns/1ps
module ctl_reg_bank_bench;

  localparam int DW = 32;
  localparam int IW = 4;
  localparam logic [31:0] SP_RESET = 32'h1000_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] sp_reg;
  logic          sp_live_we;
  logic [DW-1:0] sp_live_out;

  always #2.5 clk = ~clk;

  ctl_reg_bank u_ctl_reg_bank (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .sp_live_in  (sp_reg),
    .sp_live_we  (sp_live_we),
    .sp_live_out (sp_live_out)
  );

  // external stack-pointer register
  always_ff @(posedge clk) begin
    if (rst) sp_reg <= SP_RESET;
    else if (sp_live_we) sp_reg <= sp_live_out;
  end

  int checks = 0;
  int errors = 0;

  // reference model
  logic [7:0]  m_bst, m_cur, m_bbst;
  logic        m_cond;
  logic [31:0] m_isp, m_usp, m_live, m_bpc, m_bbpc, m_s0, m_s1;

  task automatic model_reset();
    m_bst = 0; m_cur = 0; m_bbst = 0; m_cond = 0;
    m_isp = 0; m_usp = 0; m_bpc = 0; m_bbpc = 0; m_s0 = 0; m_s1 = 0;
    m_live = SP_RESET;
  endtask

  task automatic model_write(input int idx, input logic [31:0] d);
    logic om, nm;
    om = m_cur[7];
    nm = d[7];
    case (idx)
      0: begin
        if (om && !nm) begin m_usp = m_live; m_live = m_isp; end
        else if (!om && nm) begin m_isp = m_live; m_live = m_usp; end
        m_bst = d[15:8]; m_cur = d[7:0]; m_cond = d[0];
      end
      1: m_cond = d[0];
      2: if (!om) m_live = d; else m_isp = d;
      3: if (om) m_live = d; else m_usp = d;
      4: m_s0 = d;
      5: m_s1 = d;
      6: m_bpc = d;
      7: m_bbst = d[7:0];
      8: m_bbpc = d;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input int idx);
    case (idx)
      0: return {16'h0, m_bst & 8'hC1, (m_cur & 8'hC0) | {7'b0, m_cond}};
      1: return {31'b0, m_cond};
      2: return m_cur[7] ? m_isp : m_live;
      3: return m_cur[7] ? m_live : m_usp;
      4: return m_s0;
      5: return m_s1;
      6: return m_bpc & 32'hFFFF_FFFE;
      7: return {24'h0, m_bbst & 8'hC1};
      8: return m_bbpc & 32'hFFFF_FFFE;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int idx);
    case (idx)
      0: return "R2";
      1: return "R9";
      2, 3: return "R6";
      6, 8: return "R7";
      7: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
    model_write(idx, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int idx, input string tag);
    @(negedge clk);
    rd_idx = IW'(idx);
    #1;
    chk(tag, rd_data, model_read(idx));
  endtask

  task automatic live_chk(input string tag);
    @(negedge clk);
    #1;
    chk(tag, sp_reg, m_live);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 16; i++) begin
      string t;
      t = (tag.len() != 0) ? tag : tag_of(i);
      rd_chk(i, t);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got 1 expected 0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state, and the live register is left alone
    sweep("R1");
    chk("R1", {31'b0, sp_live_we}, 32'h0);
    live_chk("R1");

    // R3 R2 R5: status all ones, mode 0 -> 1
    do_wr(0, 32'hFFFF_FFFF);
    rd_chk(0, "R2");
    rd_chk(0, "R3");
    live_chk("R5");
    rd_chk(2, "R5");
    // R6 in mode 1: user index is live, interrupt index banked
    do_wr(3, 32'hAAAA_0004);
    live_chk("R6");
    do_wr(2, 32'h5555_0008);
    live_chk("R6");
    rd_chk(2, "R6");
    rd_chk(3, "R6");
    // R4: mode 1 -> 0
    do_wr(0, 32'h0000_0000);
    live_chk("R4");
    rd_chk(3, "R4");
    rd_chk(2, "R4");
    // R5: status write keeping mode 0 does not swap
    do_wr(0, 32'h0000_3F3F);
    live_chk("R5");
    rd_chk(3, "R5");
    rd_chk(0, "R2");
    // R7 PC masking
    do_wr(6, 32'hFFFF_FFFF);
    do_wr(8, 32'h1234_5677);
    rd_chk(6, "R7");
    rd_chk(8, "R7");
    // R8 second-level backup status
    do_wr(7, 32'h1234_56FF);
    rd_chk(7, "R8");
    // R9 condition register
    do_wr(1, 32'h0000_0003);
    rd_chk(1, "R9");
    rd_chk(0, "R9");
    do_wr(1, 32'hFFFF_FFFE);
    rd_chk(1, "R9");
    // R10 scratch and unassigned
    do_wr(4, 32'hDEAD_BEEF);
    do_wr(5, 32'hCAFE_F00D);
    rd_chk(4, "R10");
    rd_chk(5, "R10");
    do_wr(12, 32'hFFFF_FFFF);
    do_wr(9, 32'hFFFF_FFFF);
    do_wr(15, 32'hFFFF_FFFF);
    sweep("R10");
    live_chk("R10");

    // constrained random writes, full sweep after each
    for (int n = 0; n < 400; n++) begin
      int idx;
      logic [31:0] d;
      idx = ($urandom % 4 == 0) ? 0 : int'($urandom % 16);
      d = $urandom;
      do_wr(idx, d);
      live_chk((idx == 0) ? "R4" : "R6");
      sweep("");
    end

    // R1 again: reset mid-run
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    model_reset();
    sweep("R1");
    live_chk("R1");

    finish_run();
  end

endmodule